// File: doc/BRIEF.md
# Peripheral Event Status and Shared Interrupt Register Block

This block is a register block on a simple bus. It serves a small group of peripherals: two timers, a byte-wide serial port and a touch-position sensor. A hardware event input sets each status flag. Software cannot write any flag. Each flag is cleared only as a side effect of one particular bus access:

- Reading the status word clears the timer overflow flags.
- Reading the receive byte clears the receive-ready flag.
- Writing the transmit byte clears the transmit-empty flag.
- Reading the touch position clears the touch flag.

An enable register selects which flags drive one shared interrupt line. A single handler reads the status word to find out which source needs service.

The block captures the received byte and the touch position when their events arrive. It presents the transmit byte, with a one-cycle load strobe, to an external shifter. The timers, the shifter and the touch sensing are outside the block. When a set event and a clearing access fall in the same cycle, the set takes priority, so no event is lost.

Top module: `evt_status_regs`

## Requirements
- R1: After reset the status word reads 0x0004 (only transmit-empty set), the enable register reads 0x0000, `irq` is 0 and `tx_load` is 0.
- R2: A one-cycle pulse on `tmr_ovf[0]` or `tmr_ovf[1]` sets status bit 0 or bit 1. A status read (address 0) returns the flags as they were before the read, then clears bits 0 and 1.
- R3: A pulse on `rx_valid` sets status bit 3 and captures `rx_byte`. A read of address 2 returns that byte zero-extended and clears bit 3.
- R4: A write to address 3 clears status bit 2. In the next cycle it shows `bus_wdata[7:0]` on `tx_data` with `tx_load` high for one cycle. A pulse on `tx_done` sets bit 2 again.
- R5: A pulse on `touch_evt` sets status bit 4 and captures `touch_pos`. A read of address 4 returns the position and clears bit 4.
- R6: A status read leaves bits 2, 3 and 4 unchanged.
- R7: Writes to addresses 0, 2 and 4 change no flag and no captured value.
- R8: When a flag's set event and its clearing access fall in the same cycle, the flag ends set. A read of that cycle returns the data held before the new event.
- R9: Address 1 is a read/write enable register. Bits [4:0] hold one enable per status bit, in the same positions. Bits above 4 read as 0.
- R10: `irq` is registered. It is high in the cycle after the AND of any flag with its enable bit is 1, and low in the cycle after no such AND is 1.
- R11: `bus_rdata` is registered and valid in the cycle after `bus_rd`. It reads 0 for unmapped addresses (5 to 7) and when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tmr_ovf | input | 2 | Timer overflow pulses |
| rx_valid | input | 1 | Received-byte pulse |
| rx_byte | input | 8 | Received byte |
| tx_done | input | 1 | Transmitter accepted byte |
| touch_evt | input | 1 | Touch event pulse |
| touch_pos | input | 16 | Touched position |
| tx_data | output | 8 | Byte to transmit |
| tx_load | output | 1 | One-cycle strobe for tx_data |
| irq | output | 1 | Shared interrupt request |

## Verification
Flags, read data and the transmit strobe each take one register stage. They are due one clock edge after the event or access that changes them. The interrupt line adds a second stage, so it follows an event or an enable write by two edges. The bench drives every stimulus on the falling edge and samples on the next falling edge, counting one edge for flags and read data and two for `irq`. It also checks `irq` after only one edge, to confirm the extra stage is present. Flag state is always observed through status reads, which clear only the timer bits. The expected words account for that side effect.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FLG_TMR0  = 0;
  localparam int FLG_TMR1  = 1;
  localparam int FLG_TXE   = 2;
  localparam int FLG_RXR   = 3;
  localparam int FLG_TCH   = 4;

  localparam logic [2:0] ADR_STATUS = 3'd0;
  localparam logic [2:0] ADR_ENABLE = 3'd1;
  localparam logic [2:0] ADR_RXDAT  = 3'd2;
  localparam logic [2:0] ADR_TXDAT  = 3'd3;
  localparam logic [2:0] ADR_TOUCH  = 3'd4;

  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 5'b00100;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 5,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= RST_VAL[i];
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    // R8: set takes priority over a clearing access
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    // R2/R3/R4/R5: a clearing access without a set empties the flag
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enable,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & enable);
  end

  a_r10_irq_rises: assert property (@(posedge clk) disable iff (rst)
    (|(flags & enable)) |=> irq);
  a_r10_irq_falls: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & enable)) |=> !irq);
endmodule

// File: rtl/evt_bus_regs.sv
module evt_bus_regs
  import evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int RX_W   = 8,
  parameter int POS_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic                 rx_valid,
  input  logic [RX_W-1:0]      rx_byte,
  input  logic                 touch_evt,
  input  logic [POS_W-1:0]     touch_pos,
  output logic [NUM_FLAGS-1:0] clr,
  output logic [NUM_FLAGS-1:0] enable,
  output logic [RX_W-1:0]      tx_data,
  output logic                 tx_load
);
  logic [RX_W-1:0]  rx_q;
  logic [POS_W-1:0] pos_q;
  logic rd_status, rd_rx, rd_touch, wr_en, wr_tx;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:RX_W];
  assign rd_status = bus_rd && (bus_addr == ADR_STATUS);
  assign rd_rx     = bus_rd && (bus_addr == ADR_RXDAT);
  assign rd_touch  = bus_rd && (bus_addr == ADR_TOUCH);
  assign wr_en     = bus_wr && (bus_addr == ADR_ENABLE);
  assign wr_tx     = bus_wr && (bus_addr == ADR_TXDAT);

  always_comb begin
    clr = '0;
    clr[FLG_TMR0] = rd_status;
    clr[FLG_TMR1] = rd_status;
    clr[FLG_TXE]  = wr_tx;
    clr[FLG_RXR]  = rd_rx;
    clr[FLG_TCH]  = rd_touch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= '0;
      rx_q    <= '0;
      pos_q   <= '0;
      tx_data <= '0;
      tx_load <= 1'b0;
    end else begin
      if (wr_en)     enable  <= bus_wdata[NUM_FLAGS-1:0];
      if (rx_valid)  rx_q    <= rx_byte;
      if (touch_evt) pos_q   <= touch_pos;
      if (wr_tx)     tx_data <= bus_wdata[RX_W-1:0];
      tx_load <= wr_tx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) bus_rdata <= '0;
    else begin
      case (bus_addr)
        ADR_STATUS: bus_rdata <= DATA_W'(flags);
        ADR_ENABLE: bus_rdata <= DATA_W'(enable);
        ADR_RXDAT:  bus_rdata <= DATA_W'(rx_q);
        ADR_TOUCH:  bus_rdata <= DATA_W'(pos_q);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  // R4: a transmit write produces the strobe and byte one cycle later
  a_r4_tx_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> (tx_load && tx_data == $past(bus_wdata[RX_W-1:0])));
  // R11: no read issued means zero read data
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
  import evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int RX_W   = 8,
  parameter int POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        tmr_ovf,
  input  logic              rx_valid,
  input  logic [RX_W-1:0]   rx_byte,
  input  logic              tx_done,
  input  logic              touch_evt,
  input  logic [POS_W-1:0]  touch_pos,
  output logic [RX_W-1:0]   tx_data,
  output logic              tx_load,
  output logic              irq
);
  logic [NUM_FLAGS-1:0] set, clr, flags, enable;

  assign set = {touch_evt, rx_valid, tx_done, tmr_ovf[1], tmr_ovf[0]};

  evt_flag_bank #(.N(NUM_FLAGS), .RST_VAL(FLAG_RST)) u_flags (
    .clk(clk), .rst(rst), .set(set), .clr(clr), .flags(flags));

  evt_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_W(RX_W), .POS_W(POS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .touch_evt(touch_evt),
    .touch_pos(touch_pos), .clr(clr), .enable(enable),
    .tx_data(tx_data), .tx_load(tx_load));

  evt_irq_gen #(.N(NUM_FLAGS)) u_irq (
    .clk(clk), .rst(rst), .flags(flags), .enable(enable), .irq(irq));

  // R7: a write to the status word alters no flag
  a_r7_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_STATUS && set == '0) |=> $stable(flags));
  // R6: a status read keeps the non-timer flags
  a_r6_status_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_STATUS) |=> (flags[4:2] >= $past(flags[4:2])));
endmodule

// File: tb/evt_status_regs_bench.sv
`timescale 1ns/1ps
module evt_status_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  tmr_ovf = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_done = 1'b0;
  logic        touch_evt = 1'b0;
  logic [15:0] touch_pos = '0;
  logic [7:0]  tx_data;
  logic        tx_load;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_status_regs u_evt_status_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_done(tx_done),
    .touch_evt(touch_evt), .touch_pos(touch_pos), .tx_data(tx_data),
    .tx_load(tx_load), .irq(irq));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic pulse_tmr(input logic [1:0] v);
    tmr_ovf = v; tick(); tmr_ovf = '0;
  endtask
  task automatic pulse_rx(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1; tick(); rx_valid = 1'b0;
  endtask
  task automatic pulse_touch(input logic [15:0] p);
    touch_pos = p; touch_evt = 1'b1; tick(); touch_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 tx_load", {15'd0, tx_load}, 16'h0);
    chk("R11 idle rdata", bus_rdata, 16'h0);
    rd(3'd1, d); chk("R1 enable", d, 16'h0000);
    rd(3'd0, d); chk("R1 status", d, 16'h0004);
    rd(3'd6, d); chk("R11 unmapped", d, 16'h0000);
  endtask

  task automatic t_timers();
    logic [15:0] d;
    pulse_tmr(2'b01);
    rd(3'd0, d); chk("R2 tmr0 set", d, 16'h0005);
    rd(3'd0, d); chk("R2 tmr0 cleared", d, 16'h0004);
    pulse_tmr(2'b10);
    rd(3'd0, d); chk("R2 tmr1 set", d, 16'h0006);
    pulse_tmr(2'b11);
    rd(3'd0, d); chk("R2 both set", d, 16'h0007);
    rd(3'd0, d); chk("R2 both cleared", d, 16'h0004);
  endtask

  task automatic t_rx();
    logic [15:0] d;
    pulse_rx(8'hA5);
    rd(3'd0, d); chk("R3 rx flag", d, 16'h000C);
    rd(3'd0, d); chk("R6 status read keeps rx", d, 16'h000C);
    rd(3'd2, d); chk("R3 rx byte", d, 16'h00A5);
    rd(3'd0, d); chk("R3 rx cleared", d, 16'h0004);
  endtask

  task automatic t_tx();
    logic [15:0] d;
    wr(3'd3, 16'hAB3C);
    chk("R4 tx_load", {15'd0, tx_load}, 16'h1);
    chk("R4 tx_data", {8'd0, tx_data}, 16'h003C);
    tick();
    chk("R4 tx_load one cycle", {15'd0, tx_load}, 16'h0);
    rd(3'd0, d); chk("R4 txe cleared", d, 16'h0000);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    rd(3'd0, d); chk("R4 txe set by done", d, 16'h0004);
  endtask

  task automatic t_touch();
    logic [15:0] d;
    pulse_touch(16'h1234);
    rd(3'd0, d); chk("R5 touch flag", d, 16'h0014);
    rd(3'd4, d); chk("R5 touch pos", d, 16'h1234);
    rd(3'd0, d); chk("R5 touch cleared", d, 16'h0004);
  endtask

  task automatic t_writes_ignored();
    logic [15:0] d;
    pulse_rx(8'h11);
    pulse_touch(16'h0BEE);
    wr(3'd0, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    rd(3'd0, d); chk("R7 status unchanged", d, 16'h001C);
    rd(3'd2, d); chk("R7 rx byte unchanged", d, 16'h0011);
    rd(3'd4, d); chk("R7 touch pos unchanged", d, 16'h0BEE);
    rd(3'd0, d); chk("R7 cleanup", d, 16'h0004);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    pulse_tmr(2'b01);
    tmr_ovf = 2'b01;
    rd(3'd0, d);
    tmr_ovf = 2'b00;
    chk("R8 read during set", d, 16'h0005);
    rd(3'd0, d); chk("R8 tmr0 survived", d, 16'h0005);
    rd(3'd0, d); chk("R8 tmr0 then cleared", d, 16'h0004);
    pulse_rx(8'h21);
    rx_byte = 8'h42; rx_valid = 1'b1;
    rd(3'd2, d);
    rx_valid = 1'b0;
    chk("R8 old byte returned", d, 16'h0021);
    rd(3'd0, d); chk("R8 rx survived", d, 16'h000C);
    rd(3'd2, d); chk("R8 new byte", d, 16'h0042);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wr(3'd1, 16'h001F);
    rd(3'd1, d); chk("R9 enable all", d, 16'h001F);
    wr(3'd1, 16'hFFE5);
    rd(3'd1, d); chk("R9 upper bits zero", d, 16'h0005);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(3'd1, 16'h0008);
    tick();
    chk("R10 masked txe no irq", {15'd0, irq}, 16'h0);
    pulse_rx(8'h77);
    chk("R10 irq registered late", {15'd0, irq}, 16'h0);
    tick();
    chk("R10 irq raised", {15'd0, irq}, 16'h1);
    rd(3'd2, d);
    chk("R10 irq held at clear edge", {15'd0, irq}, 16'h1);
    tick();
    chk("R10 irq dropped", {15'd0, irq}, 16'h0);
    wr(3'd1, 16'h0004);
    chk("R10 enable edge only", {15'd0, irq}, 16'h0);
    tick();
    chk("R10 irq from txe", {15'd0, irq}, 16'h1);
    wr(3'd1, 16'h0000);
    tick();
    chk("R10 irq off", {15'd0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_timers();
    t_rx();
    t_tx();
    t_touch();
    t_writes_ignored();
    t_set_wins();
    t_enable();
    t_irq();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule